// File: doc/BRIEF.md
# Counter-Tree Multi-Operand Adder

This block is a purely combinational adder that forms the sum of twenty-four unsigned operands of equal width. The operands arrive packed side by side in one wide input vector, and the result leaves on a single output that is wide enough to hold any possible total. No clock, no handshake and no storage are involved, so the result follows the inputs after the logic delay.

The reduction uses a tree of bitwise six-input counters instead of a chain of three-input carry-save stages. Each counter looks at one bit column of six operands and emits a three-bit population count. The three count bits are placed back into three operands with weights one, two and four, so each counter turns six operands into three. Four counters form the first level, two the second and one the third, which leaves three operands. One carry-save stage then cuts these to two, and a final carry-propagate adder produces the sum. All internal operands are zero-extended to the result width, so no carry is lost anywhere in the tree.

The tree depth is a parameter, and the operand count follows from it as six times two to the power depth minus one. The default depth of three gives twenty-four operands.

Top module: `adder_tree_24`

## Requirements
- R1: `sum_out` equals the arithmetic sum of all operands, where operand i occupies bits [i*OPD_W +: OPD_W] of `opnd_vec` and is read as an unsigned number.
- R2: When every operand is zero, `sum_out` is zero.
- R3: When every operand holds its largest value 2^OPD_W − 1, `sum_out` equals 24·(2^OPD_W − 1) with no bit lost; `sum_out` is OPD_W + 5 bits wide.
- R4: In every six-input counter, the weight-1 output plus the weight-2 output plus the weight-4 output equals the sum of its six input operands.
- R5: The carry-save stage keeps the total: its sum word plus its shifted carry word equals the sum of its three input operands.
- R6: No counter, the carry-save stage or the final adder ever produces a bit above the internal width (all spill bits stay zero).
- R7: A single non-zero operand placed in any one of the 24 slots, with all others zero, appears unchanged at `sum_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_vec | input | 24*OPD_W | All operands packed, operand i at bits [i*OPD_W +: OPD_W] |
| sum_out | output | OPD_W+5 | Unsigned sum of all operands |

## Verification
The checker modules test, whenever the inputs change, that each counter keeps the weighted total of its six operands, that the carry-save stage keeps its total, that no spill bit is ever set and that the output matches a loop sum of the operands. What only the bench scenarios can show is that the packing of operands into slots is right for every position, that the extremes (all zero, all at the maximum, a full column of ones at each bit weight) come out exactly, and that the result is right over a large set of mixed vectors in a small-width configuration.

// File: rtl/adder_tree_pkg.sv
package adder_tree_pkg;

  // Population count of one six-bit column, as a three-bit weighted count.
  function automatic logic [2:0] tally6(input logic [5:0] col);
    logic [2:0] acc;
    acc = 3'd0;
    for (int k = 0; k < 6; k++) begin
      acc = acc + {2'b00, col[k]};
    end
    return acc;
  endfunction

  // Majority of three bits: the carry of one full-adder column.
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/ct_six_to_three.sv
module ct_six_to_three #(
  parameter int W = 13
) (
  input  logic [6*W-1:0] in_ops,
  output logic [W-1:0]   w1,
  output logic [W-1:0]   w2,
  output logic [W-1:0]   w4,
  output logic [2:0]     spill
);
  import adder_tree_pkg::*;

  logic [W-1:0] z0, z1, z2;

  for (genvar j = 0; j < W; j++) begin : g_col
    logic [5:0] col;
    for (genvar k = 0; k < 6; k++) begin : g_pick
      assign col[k] = in_ops[k*W + j];
    end
    assign {z2[j], z1[j], z0[j]} = tally6(col);
  end

  assign w1    = z0;
  assign w2    = {z1[W-2:0], 1'b0};
  assign w4    = {z2[W-3:0], 2'b00};
  assign spill = {z2[W-1:W-2], z1[W-1]};

endmodule

// File: rtl/cs_compress3.sv
module cs_compress3 #(
  parameter int W = 13
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] d,
  output logic [W-1:0] s,
  output logic [W-1:0] cy,
  output logic         spill
);
  import adder_tree_pkg::*;

  logic [W-1:0] mj;

  for (genvar j = 0; j < W; j++) begin : g_fa
    assign s[j]  = a[j] ^ b[j] ^ d[j];
    assign mj[j] = maj3(a[j], b[j], d[j]);
  end

  assign cy    = {mj[W-2:0], 1'b0};
  assign spill = mj[W-1];

endmodule

// File: rtl/cp_add2.sv
module cp_add2 #(
  parameter int W = 13
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         spill
);
  logic [W:0] wide;

  assign wide  = {1'b0, a} + {1'b0, b};
  assign sum   = wide[W-1:0];
  assign spill = wide[W];

endmodule

// File: rtl/adder_tree_24.sv
module adder_tree_24 #(
  parameter int OPD_W     = 8,
  parameter int TREE_LVLS = 3,
  localparam int NUM_OPS  = 6 * (1 << (TREE_LVLS - 1)),
  localparam int SUM_W    = OPD_W + $clog2(NUM_OPS)
) (
  input  logic [NUM_OPS*OPD_W-1:0] opnd_vec,
  output logic [SUM_W-1:0]         sum_out
);
  localparam int W     = SUM_W;
  localparam int EXTRA = SUM_W - OPD_W;

  // Zero-extended operands entering the tree.
  logic [NUM_OPS*W-1:0] ext_ops;
  for (genvar i = 0; i < NUM_OPS; i++) begin : g_ext
    assign ext_ops[i*W +: W] = {{EXTRA{1'b0}}, opnd_vec[i*OPD_W +: OPD_W]};
  end

  // Named internal events for the checker.
  logic [TREE_LVLS-1:0] lvl_spill_any;
  logic [W-1:0] csa_a, csa_b, csa_d, csa_s, csa_c;
  logic         csa_spill;
  logic         fin_spill;

  // Counter tree: level l holds 2^(TREE_LVLS-1-l) six-to-three counters.
  for (genvar l = 0; l < TREE_LVLS; l++) begin : g_lvl
    localparam int CNT = 1 << (TREE_LVLS - 1 - l);
    logic [6*CNT*W-1:0] ops_in;
    logic [3*CNT*W-1:0] ops_out;
    logic [3*CNT-1:0]   sp;

    if (l == 0) begin : g_first
      assign ops_in = ext_ops;
    end else begin : g_next
      assign ops_in = g_lvl[l-1].ops_out;
    end

    for (genvar c = 0; c < CNT; c++) begin : g_ctr
      ct_six_to_three #(.W(W)) u_ctr (
        .in_ops (ops_in[c*6*W +: 6*W]),
        .w1     (ops_out[(3*c+0)*W +: W]),
        .w2     (ops_out[(3*c+1)*W +: W]),
        .w4     (ops_out[(3*c+2)*W +: W]),
        .spill  (sp[3*c +: 3])
      );
    end

    assign lvl_spill_any[l] = |sp;
  end

  assign csa_a = g_lvl[TREE_LVLS-1].ops_out[0*W +: W];
  assign csa_b = g_lvl[TREE_LVLS-1].ops_out[1*W +: W];
  assign csa_d = g_lvl[TREE_LVLS-1].ops_out[2*W +: W];

  cs_compress3 #(.W(W)) u_csa (
    .a     (csa_a),
    .b     (csa_b),
    .d     (csa_d),
    .s     (csa_s),
    .cy    (csa_c),
    .spill (csa_spill)
  );

  cp_add2 #(.W(W)) u_fin (
    .a     (csa_s),
    .b     (csa_c),
    .sum   (sum_out),
    .spill (fin_spill)
  );

endmodule

// File: rtl/adder_tree_chk.sv
module ct_six_chk #(
  parameter int W = 13
) (
  input logic [6*W-1:0] in_ops,
  input logic [W-1:0]   w1,
  input logic [W-1:0]   w2,
  input logic [W-1:0]   w4,
  input logic [2:0]     spill
);
  logic [W+2:0] in_tot, out_tot;

  always_comb begin
    in_tot = '0;
    for (int k = 0; k < 6; k++) begin
      in_tot = in_tot + {3'b000, in_ops[k*W +: W]};
    end
    out_tot = {3'b000, w1} + {3'b000, w2} + {3'b000, w4};
    // R4
    counter_total_chk: assert (out_tot == in_tot)
      else $error("counter total %0d vs inputs %0d", out_tot, in_tot);
    // R6
    counter_spill_chk: assert (spill == 3'b000)
      else $error("counter spill %b", spill);
  end
endmodule

module adder_tree_chk #(
  parameter int OPD_W     = 8,
  parameter int TREE_LVLS = 3,
  localparam int NUM_OPS  = 6 * (1 << (TREE_LVLS - 1)),
  localparam int SUM_W    = OPD_W + $clog2(NUM_OPS)
) (
  input logic [NUM_OPS*OPD_W-1:0] opnd_vec,
  input logic [SUM_W-1:0]         sum_out,
  input logic [TREE_LVLS-1:0]     lvl_spill_any,
  input logic [SUM_W-1:0]         csa_a,
  input logic [SUM_W-1:0]         csa_b,
  input logic [SUM_W-1:0]         csa_d,
  input logic [SUM_W-1:0]         csa_s,
  input logic [SUM_W-1:0]         csa_c,
  input logic                     csa_spill,
  input logic                     fin_spill
);
  logic [SUM_W+1:0] ref_sum, csa_in, csa_out;

  always_comb begin
    ref_sum = '0;
    for (int i = 0; i < NUM_OPS; i++) begin
      ref_sum = ref_sum + (SUM_W+2)'(opnd_vec[i*OPD_W +: OPD_W]);
    end
    csa_in  = {2'b00, csa_a} + {2'b00, csa_b} + {2'b00, csa_d};
    csa_out = {2'b00, csa_s} + {2'b00, csa_c};
    // R1
    sum_match_chk: assert ({2'b00, sum_out} == ref_sum)
      else $error("sum %0d vs loop sum %0d", sum_out, ref_sum);
    // R5
    csa_keep_chk: assert (csa_out == csa_in)
      else $error("csa out %0d vs in %0d", csa_out, csa_in);
    // R6
    no_overflow_chk: assert (lvl_spill_any == '0 && !csa_spill && !fin_spill)
      else $error("spill tree=%b csa=%b fin=%b", lvl_spill_any, csa_spill, fin_spill);
  end
endmodule

bind adder_tree_24 adder_tree_chk #(.OPD_W(OPD_W), .TREE_LVLS(TREE_LVLS)) u_chk (.*);
bind ct_six_to_three ct_six_chk #(.W(W)) u_cchk (.*);

// File: tb/adder_tree_24_tb.sv
module adder_tree_24_tb;
  localparam int N     = 4;
  localparam int LV    = 3;
  localparam int OPS   = 24;
  localparam int SW    = N + 5;
  localparam int MAXV  = (1 << N) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [OPS*N-1:0] opnd_vec;
  logic [SW-1:0]    sum_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  adder_tree_24 #(.OPD_W(N), .TREE_LVLS(LV)) u_dut (
    .opnd_vec (opnd_vec),
    .sum_out  (sum_out)
  );

  task automatic apply_check(input logic [OPS*N-1:0] v, input int expv, input string tag);
    @(posedge clk);
    opnd_vec = v;
    #5;
    total++;
    if (int'(sum_out) != expv) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, sum_out, expv);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [OPS*N-1:0] v;
    int e;
    opnd_vec = '0;

    // R2: all operands zero
    apply_check('0, 0, "R2 all zero");

    // R3: all operands at maximum, full-width result
    apply_check({OPS*N{1'b1}}, OPS * MAXV, "R3 all max");

    // R4: every operand equal to the same value
    for (int u = 0; u <= MAXV; u++) begin
      v = '0;
      for (int i = 0; i < OPS; i++) v[i*N +: N] = N'(u);
      apply_check(v, OPS * u, "R4 uniform value");
    end

    // R5: a full column of ones at each bit weight
    for (int b = 0; b < N; b++) begin
      v = '0;
      for (int i = 0; i < OPS; i++) v[i*N + b] = 1'b1;
      apply_check(v, OPS * (1 << b), "R5 column of ones");
    end

    // R6: alternating max and zero, then max in first k slots
    v = '0;
    for (int i = 0; i < OPS; i += 2) v[i*N +: N] = N'(MAXV);
    apply_check(v, (OPS / 2) * MAXV, "R6 alternating max");
    for (int k = 1; k <= OPS; k++) begin
      v = '0;
      for (int i = 0; i < k; i++) v[i*N +: N] = N'(MAXV);
      apply_check(v, k * MAXV, "R6 max prefix");
    end

    // R7: one non-zero operand in each slot, every value
    for (int s = 0; s < OPS; s++) begin
      for (int u = 1; u <= MAXV; u++) begin
        v = '0;
        v[s*N +: N] = N'(u);
        apply_check(v, u, "R7 single slot");
      end
    end

    // R1: mixed vectors
    for (int t = 0; t < 3000; t++) begin
      e = 0;
      for (int i = 0; i < OPS; i++) begin
        v[i*N +: N] = N'($urandom);
        e = e + int'(v[i*N +: N]);
      end
      apply_check(v, e, "R1 mixed operands");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule